// File: doc/BRIEF.md
# Shared-Network AES Column Mixer

This block transforms one 32-bit AES State column. Its mode input picks the forward column mix used in encryption or the inverse column mix used in decryption. Both directions use a single forward multiplier network. In decrypt mode the column first passes through a light pre-multiplication by the fixed polynomial {04}x² + {05}, whose product with the forward polynomial gives the inverse polynomial. The pre-multiplied column then goes through the forward network. In encrypt mode a 2:1 multiplexer per byte bypasses the pre-multiplication. The inverse coefficients {0E}, {0B}, {0D} and {09} therefore never appear as their own multiplier network.

The column is accepted with a valid strobe and the result is registered. The result and its valid flag appear one clock after the column is accepted. A parameter can remove the output register, which leaves a purely combinational path. The block does not do byte serialization, byte substitution or round-key addition.

Top module: `mixcol_unit`

## Requirements
- R1: With dec_mode = 0, each output byte i is {02}·a_i ⊕ {03}·a_(i+1) ⊕ a_(i+2) ⊕ a_(i+3), indices mod 4. Byte 0 sits at bits [31:24] and byte 3 at bits [7:0] on both the input and the output.
- R2: With dec_mode = 1, each output byte i is {0E}·a_i ⊕ {0B}·a_(i+1) ⊕ {0D}·a_(i+2) ⊕ {09}·a_(i+3), with the same byte placement as R1.
- R3: Passing any column through the forward mode and then passing that result through the inverse mode returns the original column.
- R4: Every multiplication by {02} shifts left by one bit and XORs the result with 0x1B when the bit shifted out was 1 (reduction by 0x11B). Columns with the top bit set in each byte show this.
- R5: dec_mode is sampled together with each column, so columns accepted on consecutive cycles may alternate between modes.
- R6: With the default registered output, the result of a column accepted with in_valid = 1 appears on out_col one clock later. out_valid is a one-cycle-delayed copy of in_valid.
- R7: While in_valid = 0, out_col keeps its previous value whatever in_col and dec_mode carry.
- R8: When rst_n is low at a rising clock edge, out_valid and out_col are cleared to 0 (synchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Column on in_col is to be transformed |
| dec_mode | input | 1 | 0 = forward mix, 1 = inverse mix |
| in_col | input | 32 | Input column, byte 0 at [31:24] |
| out_valid | output | 1 | out_col holds a new result |
| out_col | output | 32 | Transformed column |

## Verification
Published forward column vectors, and those vectors run back through the inverse mode, test the coefficient rotation and byte order in both modes. A column with a single 0x80 byte and an all-0x80 column exercise the modular reduction on every byte lane. Two hundred random columns sent through forward then inverse mode show that the shared network together with the pre-step is an exact inverse. Columns that alternate modes on consecutive cycles, and idle cycles with changing input, separate per-column mode sampling from the output register's hold behaviour.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] gbyte_t;
  typedef logic [COL_W-1:0]  gcol_t;

  // modular doubling in GF(2^8)
  function automatic gbyte_t gf_x2(gbyte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
  endfunction

  function automatic gbyte_t gf_x3(gbyte_t a);
    return gf_x2(a) ^ a;
  endfunction

  function automatic gbyte_t gf_x4(gbyte_t a);
    return gf_x2(gf_x2(a));
  endfunction

  function automatic gbyte_t gf_x5(gbyte_t a);
    return gf_x4(a) ^ a;
  endfunction

  function automatic gbyte_t gf_x8(gbyte_t a);
    return gf_x2(gf_x4(a));
  endfunction
endpackage

// File: rtl/mixcol_prestep.sv
module mixcol_prestep
  import mixcol_pkg::*;
(
  input  logic        dec,
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  // multiply by {04}x^2 + {05} when decrypting, pass through otherwise
  for (genvar i = 0; i < COL_BYTES; i++) begin : g_byte
    localparam int HI  = COL_W - 1 - i * BYTE_W;
    localparam int OPP = (i + 2) % COL_BYTES;
    localparam int OHI = COL_W - 1 - OPP * BYTE_W;
    gbyte_t own_b, opp_b, mul_b;
    assign own_b = col_i[HI -: BYTE_W];
    assign opp_b = col_i[OHI -: BYTE_W];
    assign mul_b = gf_x5(own_b) ^ gf_x4(opp_b);
    assign col_o[HI -: BYTE_W] = dec ? mul_b : own_b;
  end
endmodule

// File: rtl/mixcol_fwd.sv
module mixcol_fwd
  import mixcol_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  gbyte_t b [COL_BYTES];

  for (genvar j = 0; j < COL_BYTES; j++) begin : g_split
    assign b[j] = col_i[COL_W-1-j*BYTE_W -: BYTE_W];
  end

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_row
    assign col_o[COL_W-1-i*BYTE_W -: BYTE_W] =
        gf_x2(b[i]) ^ gf_x3(b[(i+1)%COL_BYTES]) ^
        b[(i+2)%COL_BYTES] ^ b[(i+3)%COL_BYTES];
  end
endmodule

// File: rtl/mixcol_outreg.sv
module mixcol_outreg
  import mixcol_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [COL_W-1:0] col_i,
  output logic             vld_o,
  output logic [COL_W-1:0] col_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_o <= 1'b0;
        col_o <= '0;
      end else begin
        vld_o <= vld_i;
        if (vld_i) col_o <= col_i;
      end
    end
  end else begin : g_comb
    assign vld_o = vld_i;
    assign col_o = col_i;
  end
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
  import mixcol_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             dec_mode,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);
  logic [COL_W-1:0] pre_col;
  logic [COL_W-1:0] fwd_col;

  mixcol_prestep u_pre (
    .dec   (dec_mode),
    .col_i (in_col),
    .col_o (pre_col)
  );

  mixcol_fwd u_fwd (
    .col_i (pre_col),
    .col_o (fwd_col)
  );

  mixcol_outreg #(.OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .col_i (fwd_col),
    .vld_o (out_valid),
    .col_o (out_col)
  );
endmodule

// File: rtl/mixcol_unit_chk.sv
module mixcol_unit_chk
  import mixcol_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             dec_mode,
  input logic [COL_W-1:0] in_col,
  input logic             out_valid,
  input logic [COL_W-1:0] out_col
);
  // inverse matrix built directly from the 0E/0B/0D/09 coefficients
  function automatic gcol_t chk_inv(gcol_t c);
    gbyte_t a [COL_BYTES];
    gcol_t  r;
    for (int j = 0; j < COL_BYTES; j++) a[j] = c[COL_W-1-j*BYTE_W -: BYTE_W];
    for (int i = 0; i < COL_BYTES; i++) begin
      gbyte_t p0, p1, p2, p3;
      p0 = a[i];
      p1 = a[(i+1)%COL_BYTES];
      p2 = a[(i+2)%COL_BYTES];
      p3 = a[(i+3)%COL_BYTES];
      r[COL_W-1-i*BYTE_W -: BYTE_W] =
          (gf_x8(p0) ^ gf_x4(p0) ^ gf_x2(p0)) ^
          (gf_x8(p1) ^ gf_x2(p1) ^ p1) ^
          (gf_x8(p2) ^ gf_x4(p2) ^ p2) ^
          (gf_x8(p3) ^ p3);
    end
    return r;
  endfunction

  function automatic gcol_t chk_fwd(gcol_t c);
    gbyte_t a [COL_BYTES];
    gcol_t  r;
    for (int j = 0; j < COL_BYTES; j++) a[j] = c[COL_W-1-j*BYTE_W -: BYTE_W];
    for (int i = 0; i < COL_BYTES; i++)
      r[COL_W-1-i*BYTE_W -: BYTE_W] = gf_x2(a[i]) ^ gf_x3(a[(i+1)%COL_BYTES]) ^
                                      a[(i+2)%COL_BYTES] ^ a[(i+3)%COL_BYTES];
    return r;
  endfunction

  if (OUT_REG) begin : g_seq
    a_r1_enc_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_mode) |=> (chk_inv(out_col) == $past(in_col)));

    a_r2_dec_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_mode) |=> (chk_fwd(out_col) == $past(in_col)));

    a_r6_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    a_r6_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_col));

    a_r8_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_col == '0));
  end
endmodule

bind mixcol_unit mixcol_unit_chk #(.OUT_REG(OUT_REG)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .dec_mode  (dec_mode),
  .in_col    (in_col),
  .out_valid (out_valid),
  .out_col   (out_col)
);

// File: tb/mixcol_unit_tb_top.sv
module mixcol_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        dec_mode = 1'b0;
  logic [31:0] in_col = '0;
  logic        out_valid;
  logic [31:0] out_col;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mixcol_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_mode(dec_mode),
    .in_col(in_col), .out_valid(out_valid), .out_col(out_col)
  );

  // {mode, input, expected}
  localparam logic [64:0] VEC [12] = '{
    {1'b0, 32'hdb135345, 32'h8e4da1bc},
    {1'b0, 32'hf20a225c, 32'h9fdc589d},
    {1'b0, 32'h01010101, 32'h01010101},
    {1'b0, 32'hc6c6c6c6, 32'hc6c6c6c6},
    {1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6},
    {1'b0, 32'h2d26314c, 32'h4d7ebdf8},
    {1'b1, 32'h8e4da1bc, 32'hdb135345},
    {1'b1, 32'h9fdc589d, 32'hf20a225c},
    {1'b1, 32'hd5d5d7d6, 32'hd4d4d4d5},
    {1'b1, 32'h4d7ebdf8, 32'h2d26314c},
    {1'b0, 32'h00000000, 32'h00000000},
    {1'b1, 32'h00000000, 32'h00000000}
  };

  // generic shift-and-add multiply
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] aa = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p ^= aa;
      aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1b) : {aa[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [31:0] ref_mat(input logic [31:0] c, input logic [31:0] coef);
    logic [7:0]  a [4];
    logic [31:0] r;
    for (int j = 0; j < 4; j++) a[j] = c[31-8*j -: 8];
    for (int i = 0; i < 4; i++) begin
      logic [7:0] acc = '0;
      for (int j = 0; j < 4; j++) acc ^= gmul(a[(i+j)%4], coef[31-8*j -: 8]);
      r[31-8*i -: 8] = acc;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_enc(input logic [31:0] c);
    return ref_mat(c, 32'h02030101);
  endfunction

  function automatic logic [31:0] ref_dec(input logic [31:0] c);
    return ref_mat(c, 32'h0e0b0d09);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run_one(input logic m, input logic [31:0] c, output logic [31:0] r);
    @(negedge clk);
    in_valid = 1'b1; dec_mode = m; in_col = c;
    @(negedge clk);
    r = out_col;
    check("R6 out_valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, y, hold;
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", {31'b0, out_valid}, 32'd0);
    check("R8 reset out_col", out_col, 32'd0);
    rst_n = 1'b1;

    // R1 / R2 known vectors
    for (int v = 0; v < 12; v++) begin
      run_one(VEC[v][64], VEC[v][63:32], r);
      check(VEC[v][64] ? "R2 dec vector" : "R1 enc vector", r, VEC[v][31:0]);
    end

    // R4 reduction corner cases
    run_one(1'b0, 32'h80000000, r);
    check("R4 enc single 0x80", r, 32'h1b80809b);
    run_one(1'b0, 32'h80808080, r);
    check("R4 enc all 0x80", r, ref_enc(32'h80808080));
    run_one(1'b1, 32'h80000000, r);
    check("R4 dec single 0x80", r, ref_dec(32'h80000000));
    run_one(1'b1, 32'hffffffff, r);
    check("R4 dec all 0xff", r, ref_dec(32'hffffffff));

    // R3 round trip on random columns
    for (int k = 0; k < 200; k++) begin
      logic [31:0] x;
      x = $urandom;
      run_one(1'b0, x, y);
      check("R1 random enc", y, ref_enc(x));
      run_one(1'b1, y, r);
      check("R3 round trip", r, x);
    end

    // R5 mode alternating on consecutive cycles
    @(negedge clk);
    in_valid = 1'b1; dec_mode = 1'b0; in_col = 32'hdb135345;
    @(negedge clk);
    check("R5 first enc", out_col, 32'h8e4da1bc);
    in_valid = 1'b1; dec_mode = 1'b1; in_col = 32'h8e4da1bc;
    @(negedge clk);
    check("R5 then dec", out_col, 32'hdb135345);
    in_valid = 1'b1; dec_mode = 1'b0; in_col = 32'h2d26314c;
    @(negedge clk);
    check("R5 then enc", out_col, 32'h4d7ebdf8);
    hold = out_col;

    // R7 idle input ignored, R6 valid drops
    in_valid = 1'b0; dec_mode = 1'b1; in_col = 32'h12345678;
    @(negedge clk);
    check("R7 hold after idle", out_col, hold);
    check("R6 out_valid low", {31'b0, out_valid}, 32'd0);
    dec_mode = 1'b0; in_col = 32'hcafef00d;
    @(negedge clk);
    check("R7 hold second idle", out_col, hold);

    // R8 reset mid-run
    run_one(1'b0, 32'hf20a225c, r);
    check("R1 before reset", r, 32'h9fdc589d);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset out_col", out_col, 32'd0);
    check("R8 mid reset out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule